// File: doc/BRIEF.md
# Clock-Ratio-Weighted Dual Performance Counter

This block holds two independent event counters that a CPU debug unit uses to measure stall cycles and similar per-cycle conditions. Each channel has its own run state, started and stopped by single-cycle pulses. While running, it adds to its count in every cycle that its event strobe is high.

A channel works in one of two modes. In plain mode each qualifying cycle adds one. In weighted mode it adds a step taken from the CPU-to-bus clock ratio in effect in that cycle. The step is 24 divided by the ratio, so count × bus period / 24 stays equal to elapsed time even when software changes the ratio mid-run. One typical use pairs a cache-miss strobe on one channel with a cacheable-access strobe on the other to derive a hit ratio.

Counters saturate instead of wrapping and keep sticky overflow and ratio-error flags. A synchronous clear wipes counts and flags.

Top module: `perf_dual_counter`

## Requirements
- R1: After reset every count is zero, all overflow and error flags are low, and both channels are stopped.
- R2: In plain mode (weighted select low), a running channel with its event strobe high adds exactly 1 per clock.
- R3: In weighted mode, a running channel with its event high adds a step chosen by the 3-bit ratio code. Code 0 (ratio 1) adds 24, code 1 (ratio 2) adds 12, code 2 (ratio 3) adds 8, code 3 (ratio 4) adds 6, code 4 (ratio 6) adds 4, and code 5 (ratio 8) adds 3.
- R4: The ratio code is used in the same cycle it is presented, so a change between two counting cycles changes the step from that cycle on.
- R5: A start pulse makes the channel run from the next cycle, and a stop pulse halts it from the next cycle. An event in the stop cycle still counts, an event in the start cycle does not, and stop wins over start in the same cycle. A stopped channel, or a cycle with the event low, leaves the count unchanged.
- R6: A count that would pass all-ones stays at all-ones and sets the channel's overflow flag. The flag stays set until a clear.
- R7: Clear zeroes both counts, overflow flags and error flags in the next cycle and overrides any counting in that cycle. It leaves the run state unchanged.
- R8: In weighted mode a ratio code of 6 or 7 adds 1 and sets the channel's sticky error flag. In plain mode these codes have no effect on the error flag.
- R9: The two channels are independent: each has its own start, stop, event and mode inputs, and they share only the ratio code and the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | CPU clock |
| rst_ni | input | 1 | Active-low reset |
| clr_i | input | 1 | Synchronous clear of counts and flags |
| start_i | input | NUM_CH | Per-channel start pulse |
| stop_i | input | NUM_CH | Per-channel stop pulse |
| event_i | input | NUM_CH | Per-channel qualifying-cycle strobe |
| weighted_i | input | NUM_CH | Per-channel mode: 1 = weighted, 0 = plain |
| ratio_code_i | input | 3 | Current CPU-to-bus clock ratio code |
| cnt_o | output | NUM_CH*CNT_W | Counts, channel c at bits [c*CNT_W +: CNT_W] |
| ovf_o | output | NUM_CH | Sticky saturation flags |
| err_o | output | NUM_CH | Sticky invalid-ratio flags |

## Verification
Several functions can fall in one cycle. Clear can land on a counting event or on the cycle that saturates a counter. Start and stop can arrive together. The step that reaches all-ones can come from an invalid code in weighted mode. A ratio change can arrive between two counting cycles. Directed sequences force each of these pairings. A long run of seeded random stimulus with frequent strobes and occasional clears then produces them again at random. Every cycle is compared against a bench model that applies clear first, then the count, then the run-state update.

// File: rtl/perf_pkg.sv
package perf_pkg;
    localparam int RC_W   = 3;
    localparam int STEP_W = 5;

    typedef enum logic [RC_W-1:0] {
        RC_DIV1 = 3'd0,
        RC_DIV2 = 3'd1,
        RC_DIV3 = 3'd2,
        RC_DIV4 = 3'd3,
        RC_DIV6 = 3'd4,
        RC_DIV8 = 3'd5
    } ratio_code_e;

    localparam logic [STEP_W-1:0] TIME_BASE = 5'd24;
endpackage

// File: rtl/perf_step_lut.sv
module perf_step_lut
    import perf_pkg::*;
(
    input  logic [RC_W-1:0]   code_i,
    output logic [STEP_W-1:0] step_o,
    output logic              valid_o
);
    logic [3:0] ratio;

    always_comb begin
        valid_o = 1'b1;
        unique case (code_i)
            RC_DIV1: ratio = 4'd1;
            RC_DIV2: ratio = 4'd2;
            RC_DIV3: ratio = 4'd3;
            RC_DIV4: ratio = 4'd4;
            RC_DIV6: ratio = 4'd6;
            RC_DIV8: ratio = 4'd8;
            default: begin
                ratio   = 4'd1;
                valid_o = 1'b0;
            end
        endcase
        step_o = valid_o ? STEP_W'(TIME_BASE / STEP_W'(ratio)) : STEP_W'(1);
    end

    always_comb begin
        if (valid_o) begin
            AST_STEP_TIMES_RATIO: assert (32'(step_o) * 32'(ratio) == 32'(TIME_BASE)); // R3
        end
    end
endmodule

// File: rtl/perf_channel.sv
module perf_channel
    import perf_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              clr_i,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic              event_i,
    input  logic              weighted_i,
    input  logic [STEP_W-1:0] step_i,
    input  logic              step_ok_i,
    output logic [CNT_W-1:0]  cnt_o,
    output logic              ovf_o,
    output logic              err_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic             run;
        logic [CNT_W-1:0] cnt;
        logic             ovf;
        logic             err;
    } chan_t;

    chan_t st_d, st_q;
    logic [CNT_W:0]        sum;
    logic [STEP_W-1:0]     inc;
    logic                  hit;

    always_comb begin
        st_d = st_q;
        hit  = st_q.run && event_i;
        inc  = (weighted_i && step_ok_i) ? step_i : STEP_W'(1);
        sum  = {1'b0, st_q.cnt} + (CNT_W+1)'(inc);
        if (clr_i) begin
            st_d.cnt = '0;
            st_d.ovf = 1'b0;
            st_d.err = 1'b0;
        end else if (hit) begin
            if (weighted_i && !step_ok_i) st_d.err = 1'b1;
            if (sum > {1'b0, CNT_MAX}) begin
                st_d.cnt = CNT_MAX;
                st_d.ovf = 1'b1;
            end else begin
                st_d.cnt = sum[CNT_W-1:0];
            end
        end
        if (stop_i)       st_d.run = 1'b0;
        else if (start_i) st_d.run = 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;
    assign ovf_o = st_q.ovf;
    assign err_o = st_q.err;

    AST_CLR_WIPES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_i |=> (cnt_o == '0 && !ovf_o && !err_o)); // R7
    AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!clr_i && !(st_q.run && event_i)) |=> $stable(cnt_o)); // R5
    AST_PLAIN_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!clr_i && st_q.run && event_i && !weighted_i && cnt_o != CNT_MAX)
        |=> cnt_o == $past(cnt_o) + 1'b1); // R2
    AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ovf_o && !clr_i) |=> ovf_o); // R6
    AST_SAT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cnt_o == CNT_MAX && !clr_i) |=> cnt_o == CNT_MAX); // R6
    AST_STOP_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stop_i |=> !st_q.run); // R5
endmodule

// File: rtl/perf_dual_counter.sv
module perf_dual_counter
    import perf_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int CNT_W  = 32
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic                    clr_i,
    input  logic [NUM_CH-1:0]       start_i,
    input  logic [NUM_CH-1:0]       stop_i,
    input  logic [NUM_CH-1:0]       event_i,
    input  logic [NUM_CH-1:0]       weighted_i,
    input  logic [2:0]              ratio_code_i,
    output logic [NUM_CH*CNT_W-1:0] cnt_o,
    output logic [NUM_CH-1:0]       ovf_o,
    output logic [NUM_CH-1:0]       err_o
);
    logic [STEP_W-1:0] step;
    logic              step_ok;

    perf_step_lut u_lut (
        .code_i  (ratio_code_i),
        .step_o  (step),
        .valid_o (step_ok)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        perf_channel #(.CNT_W(CNT_W)) u_ch (
            .clk_i      (clk_i),
            .rst_ni     (rst_ni),
            .clr_i      (clr_i),
            .start_i    (start_i[c]),
            .stop_i     (stop_i[c]),
            .event_i    (event_i[c]),
            .weighted_i (weighted_i[c]),
            .step_i     (step),
            .step_ok_i  (step_ok),
            .cnt_o      (cnt_o[c*CNT_W +: CNT_W]),
            .ovf_o      (ovf_o[c]),
            .err_o      (err_o[c])
        );
    end
endmodule

// File: tb/perf_dual_counter_tb.sv
module perf_dual_counter_tb_top;
    localparam int NCH = 2;
    localparam int CW  = 10;
    localparam int MAXV = (1 << CW) - 1;

    logic clk = 0, rst_n = 0, clr = 0;
    logic [NCH-1:0] start = 0, stop = 0, ev = 0, wt = 0;
    logic [2:0] code = 0;
    logic [NCH*CW-1:0] cnt;
    logic [NCH-1:0] ovf, err;

    int m_cnt [NCH];
    bit m_run [NCH], m_ovf [NCH], m_err [NCH];
    int n_tests = 0, n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    perf_dual_counter #(.NUM_CH(NCH), .CNT_W(CW)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .clr_i(clr), .start_i(start), .stop_i(stop),
        .event_i(ev), .weighted_i(wt), .ratio_code_i(code),
        .cnt_o(cnt), .ovf_o(ovf), .err_o(err));

    function automatic int step_of(input logic [2:0] c);
        case (c)
            3'd0: return 24;  3'd1: return 12; 3'd2: return 8;
            3'd3: return 6;   3'd4: return 4;  3'd5: return 3;
            default: return 0;
        endcase
    endfunction

    task automatic model_edge();
        for (int c = 0; c < NCH; c++) begin
            if (clr) begin
                m_cnt[c] = 0; m_ovf[c] = 0; m_err[c] = 0;
            end else if (m_run[c] && ev[c]) begin
                int inc = 1;
                if (wt[c]) begin
                    if (step_of(code) == 0) m_err[c] = 1;
                    else inc = step_of(code);
                end
                if (m_cnt[c] + inc > MAXV) begin m_cnt[c] = MAXV; m_ovf[c] = 1; end
                else m_cnt[c] = m_cnt[c] + inc;
            end
            if (stop[c]) m_run[c] = 0;
            else if (start[c]) m_run[c] = 1;
        end
    endtask

    task automatic compare(input string tag);
        for (int c = 0; c < NCH; c++) begin
            n_tests++;
            if (int'(cnt[c*CW +: CW]) != m_cnt[c]) begin
                n_fail++;
                $display("FAIL %s ch%0d count actual %0d expected %0d", tag, c, cnt[c*CW +: CW], m_cnt[c]);
            end
            n_tests++;
            if (ovf[c] != m_ovf[c] || err[c] != m_err[c]) begin
                n_fail++;
                $display("FAIL %s ch%0d flags ovf/err actual %0b/%0b expected %0b/%0b",
                         tag, c, ovf[c], err[c], m_ovf[c], m_err[c]);
            end
        end
    endtask

    // inputs applied after a negedge; model advanced; outputs checked at the next negedge
    task automatic cyc(input logic cl, input logic [1:0] st, input logic [1:0] sp,
                       input logic [1:0] e, input logic [1:0] w, input logic [2:0] rc,
                       input string tag);
        clr = cl; start = st; stop = sp; ev = e; wt = w; code = rc;
        model_edge();
        @(posedge clk);
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        for (int c = 0; c < NCH; c++) begin m_cnt[c] = 0; m_run[c] = 0; m_ovf[c] = 0; m_err[c] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        compare("R1");
        cyc(0, 2'b00, 2'b00, 2'b11, 2'b00, 0, "R1");        // stopped after reset: no count
        cyc(0, 2'b11, 2'b00, 2'b11, 2'b10, 0, "R5");        // event in start cycle not counted
        cyc(0, 0, 0, 2'b01, 2'b10, 0, "R2");
        cyc(0, 0, 0, 2'b01, 2'b10, 0, "R2");
        cyc(0, 0, 0, 2'b01, 2'b10, 0, "R2");
        for (int k = 0; k < 6; k++) cyc(0, 0, 0, 2'b10, 2'b10, 3'(k), "R3");
        cyc(0, 0, 0, 2'b10, 2'b10, 3'd5, "R4");
        cyc(0, 0, 0, 2'b10, 2'b10, 3'd0, "R4");
        cyc(0, 0, 0, 2'b10, 2'b10, 3'd3, "R4");
        cyc(0, 0, 0, 2'b00, 2'b11, 3'd0, "R5");             // event low
        cyc(0, 0, 2'b10, 2'b11, 2'b00, 0, "R5");            // event in stop cycle counts
        cyc(0, 0, 0, 2'b11, 2'b00, 0, "R9");                // ch1 stopped, ch0 counts
        cyc(0, 2'b10, 2'b10, 2'b00, 0, 0, "R5");            // stop wins
        cyc(0, 0, 0, 2'b10, 0, 0, "R5");
        cyc(1, 0, 0, 2'b11, 2'b11, 0, "R7");                // clear beats counting
        cyc(0, 0, 0, 2'b01, 0, 0, "R7");                    // run state survives clear
        cyc(0, 0, 0, 2'b01, 2'b01, 3'd6, "R8");
        cyc(0, 0, 0, 2'b01, 2'b01, 3'd7, "R8");
        cyc(0, 2'b10, 0, 2'b01, 2'b00, 3'd7, "R8");          // plain mode: no error
        cyc(0, 0, 0, 2'b10, 2'b00, 3'd6, "R8");
        for (int k = 0; k < 50; k++) cyc(0, 0, 0, 2'b01, 2'b01, 3'd0, "R6");
        cyc(0, 0, 0, 2'b01, 2'b00, 3'd0, "R6");
        cyc(1, 0, 0, 2'b11, 2'b11, 3'd0, "R7");              // clear on saturated counter
        for (int k = 0; k < 4000; k++) begin
            logic [31:0] r = $urandom;
            cyc((r[7:0] == 0), {r[8]  & r[9],  r[10] & r[11]}, {r[12] & r[13] & r[14], r[15] & r[16] & r[17]},
                {r[18] | r[19], r[20] | r[21]}, {r[22] | r[23], r[24]}, r[27:25], "R9");
        end
        done = 1;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                n_tests++; n_fail++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule